// File: doc/BRIEF.md
# Programmable Scaled Clock Divider

This block turns a prescaled clock-enable tick into a slower scaled tick. Two groups, A and B, are built the same way. Each group has an 8-bit scale register and a down-counter that advances only on that group's input tick. When the counter reaches its terminal count, it reloads from the scale register and flips a toggle stage. The toggle stage gives a built-in divide-by-two, so the scaled clock runs at the input tick rate divided by twice the scale value. A scale of zero stands for 256.

Software writes a scale value through a plain strobe port and can read both registers back at any time. A write always reloads the counter immediately and clears the toggle stage, whether the new value differs from the old one or not. Each output channel has one select bit. That bit passes either its group's raw input tick or its group's scaled tick to the channel's counters further down the chip.

All outputs are single-cycle enables in the system clock domain. The block generates no derived clock.

Top module: `scaled_clk_div`

## Requirements
- R1: After reset, both scale read-back fields are 0x00 and both `sc_tick` and `sc_level` bits are 0.
- R2: A write (`wr_en`=1) stores `wr_data` into group A when `wr_sel`=0 or group B when `wr_sel`=1. The new value shows on `rd_scale` (A in bits 7:0, B in bits 15:8) from the next cycle. The other group's field is unchanged.
- R3: After a write of scale S, the first `sc_tick` of that group follows the S-th input tick, with S=0 meaning 256. It is high in the cycle after the clock edge that samples that tick.
- R4: Later `sc_tick` pulses of a group are spaced 2·S input ticks apart, and 512 apart when S=0.
- R5: `sc_level` toggles every S input ticks. It goes high exactly in the cycles where `sc_tick` is high. A write to the group forces it to 0.
- R6: A write in the middle of a count reloads the counter with the written value, even when the value equals the current one. If an input tick coincides with the write, the write wins and that tick is not counted.
- R7: `sc_tick` is never high in two consecutive cycles.
- R8: A group's counter advances only on its own `in_tick` bit (bit 0 for A, bit 1 for B). No `sc_tick` follows a cycle without an input tick for that group.
- R9: `ch_tick[i]` equals `sc_tick[g]` when `ch_sel[i]`=1 and `in_tick[g]` when `ch_sel[i]`=0, with no register delay. The group g is bit 1 of the channel index (channels 0,1,4,5 use A; channels 2,3,6,7 use B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the scale registers |
| wr_sel | input | 1 | Target group of the write: 0 = A, 1 = B |
| wr_data | input | 8 | Scale value to write |
| rd_scale | output | 16 | Read-back: A in bits 7:0, B in bits 15:8 |
| in_tick | input | 2 | Prescaled input ticks, bit 0 = A, bit 1 = B |
| sc_tick | output | 2 | Scaled single-cycle ticks per group |
| sc_level | output | 2 | Scaled square-wave level per group |
| ch_sel | input | 8 | Per-channel choice: 1 = scaled, 0 = unscaled |
| ch_tick | output | 8 | Selected tick per channel |

## Verification
A register write and a terminal-count input tick can land on the same clock edge, and the block has to settle which one wins. The bench arms a scale of 2 and advances one tick, which leaves the counter one tick from terminal. It then raises the strobe and the group's tick together. The write is judged the winner when three things hold: no scaled tick appears, the level stays low, and the next pulse arrives a full two ticks later rather than at once. Rewriting the same value mid-count is judged the same way, by the restarted spacing.

// File: rtl/scdiv_pkg.sv
package scdiv_pkg;
  localparam int unsigned N_GRP = 2;

  // group that feeds an output channel: bit 1 of the channel index
  function automatic int unsigned grp_of(input int unsigned ch);
    return (ch >> 1) % N_GRP;
  endfunction
endpackage

// File: rtl/scdiv_scale_reg.sv
module scdiv_scale_reg #(
  parameter int unsigned SCALE_W = 8,
  parameter bit          GRP_ID  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [SCALE_W-1:0] wr_data,
  output logic [SCALE_W-1:0] scale_q,
  output logic               load
);
  logic [SCALE_W-1:0] scale_d;

  assign load = wr_en && (wr_sel == GRP_ID);

  always_comb begin
    scale_d = scale_q;
    if (load) scale_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scale_q <= '0;
    else        scale_q <= scale_d;
  end
endmodule

// File: rtl/scdiv_counter.sv
module scdiv_counter #(
  parameter int unsigned SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SCALE_W-1:0] load_val,
  input  logic [SCALE_W-1:0] scale,
  input  logic               tick_in,
  output logic               tick_out,
  output logic               level
);
  localparam logic [SCALE_W-1:0] TERM = {{(SCALE_W-1){1'b0}}, 1'b1};

  logic [SCALE_W-1:0] cnt_q, cnt_d;
  logic               lvl_d, tick_d;
  logic               at_term;

  assign at_term = (cnt_q == TERM);

  // zero loaded wraps to all ones on the first tick, so it spans 2**SCALE_W ticks
  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = level;
    tick_d = 1'b0;
    if (load) begin
      cnt_d = load_val;
      lvl_d = 1'b0;
    end else if (tick_in) begin
      if (at_term) begin
        cnt_d  = scale;
        lvl_d  = ~level;
        tick_d = ~level;
      end else begin
        cnt_d = cnt_q - TERM;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      level    <= 1'b0;
      tick_out <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      level    <= lvl_d;
      tick_out <= tick_d;
    end
  end
endmodule

// File: rtl/scdiv_src_sel.sv
module scdiv_src_sel #(
  parameter int unsigned N_CH = 8
) (
  input  logic [scdiv_pkg::N_GRP-1:0] raw_tick,
  input  logic [scdiv_pkg::N_GRP-1:0] scaled_tick,
  input  logic [N_CH-1:0]             sel,
  output logic [N_CH-1:0]             out_tick
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam int unsigned G = scdiv_pkg::grp_of(i);
    assign out_tick[i] = sel[i] ? scaled_tick[G] : raw_tick[G];
  end
endmodule

// File: rtl/scaled_clk_div.sv
module scaled_clk_div #(
  parameter int unsigned SCALE_W = 8,
  parameter int unsigned N_CH    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_sel,
  input  logic [SCALE_W-1:0]     wr_data,
  output logic [2*SCALE_W-1:0]   rd_scale,
  input  logic [1:0]             in_tick,
  output logic [1:0]             sc_tick,
  output logic [1:0]             sc_level,
  input  logic [N_CH-1:0]        ch_sel,
  output logic [N_CH-1:0]        ch_tick
);
  localparam int unsigned NG = scdiv_pkg::N_GRP;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [SCALE_W-1:0] scale_q;
    logic               load;

    scdiv_scale_reg #(.SCALE_W(SCALE_W), .GRP_ID(g[0])) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .scale_q(scale_q), .load(load)
    );

    scdiv_counter #(.SCALE_W(SCALE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data),
      .scale(scale_q), .tick_in(in_tick[g]),
      .tick_out(sc_tick[g]), .level(sc_level[g])
    );

    assign rd_scale[g*SCALE_W +: SCALE_W] = scale_q;
  end

  scdiv_src_sel #(.N_CH(N_CH)) u_sel (
    .raw_tick(in_tick), .scaled_tick(sc_tick), .sel(ch_sel), .out_tick(ch_tick)
  );
endmodule

// File: rtl/scdiv_chk.sv
module scdiv_chk #(
  parameter int unsigned SCALE_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 wr_sel,
  input logic [SCALE_W-1:0]   wr_data,
  input logic [2*SCALE_W-1:0] rd_scale,
  input logic [1:0]           in_tick,
  input logic [1:0]           sc_tick,
  input logic [1:0]           sc_level
);
  for (genvar g = 0; g < 2; g++) begin : g_a
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sc_tick[g] |=> !sc_tick[g]);
    p_tick_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sc_tick[g] |-> $rose(sc_level[g]));
    p_wr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == g[0]) |=> (!sc_level[g] && !sc_tick[g]));
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == g[0]) |=> rd_scale[g*SCALE_W +: SCALE_W] == $past(wr_data));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == g[0]) |=> $stable(rd_scale[g*SCALE_W +: SCALE_W]));
    p_need_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_tick[g] |=> !sc_tick[g]);
  end
endmodule

bind scaled_clk_div scdiv_chk #(.SCALE_W(SCALE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_scale(rd_scale), .in_tick(in_tick), .sc_tick(sc_tick), .sc_level(sc_level)
);

// File: tb/sim_scaled_clk_div.sv
module sim_scaled_clk_div;
  logic        clk, rst_n, wr_en, wr_sel;
  logic [7:0]  wr_data;
  logic [15:0] rd_scale;
  logic [1:0]  in_tick, sc_tick, sc_level;
  logic [7:0]  ch_sel, ch_tick;
  int n_vec = 0, n_err = 0;
  bit done = 0;

  scaled_clk_div u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_scale(rd_scale), .in_tick(in_tick), .sc_tick(sc_tick),
    .sc_level(sc_level), .ch_sel(ch_sel), .ch_tick(ch_tick));

  initial clk = 0;
  always #5 clk = ~clk;

  // group, scale, idle cycles between ticks, expected ticks to first pulse
  localparam int VG[7]   = '{0, 0, 1, 0, 1, 1, 0};
  localparam int VS[7]   = '{1, 2, 255, 0, 0, 3, 5};
  localparam int VGAP[7] = '{0, 0, 0, 0, 0, 2, 1};
  localparam int VEXP[7] = '{1, 2, 255, 256, 256, 3, 5};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int g, input int val);
    wr_en = 1; wr_sel = g[0]; wr_data = val[7:0];
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input int g, input int gap, output bit seen);
    in_tick[g] = 1;
    @(posedge clk); @(negedge clk);
    in_tick[g] = 0;
    seen = sc_tick[g];
    for (int k = 0; k < gap; k++) begin
      @(posedge clk); @(negedge clk);
      if (sc_tick[g]) chk(0, "R7/R8 tick without input", 1, 0);
    end
  endtask

  task automatic count_to(input int g, input int gap, output int n);
    bit seen;
    n = 0;
    do begin
      pulse(g, gap, seen);
      n++;
      if (sc_tick[1-g]) chk(0, "R8 idle group ticked", 1, 0);
    end while (!seen && n < 700);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; in_tick = 0; ch_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_scale == 16'h0, "R1 read-back", rd_scale, 0);
    chk(sc_tick == 0 && sc_level == 0, "R1 outputs", {sc_tick, sc_level}, 0);

    wr(1, 8'h5A);
    chk(rd_scale == 16'h5A00, "R2 write B", rd_scale, 16'h5A00);
    wr(0, 8'hC3);
    chk(rd_scale == 16'h5AC3, "R2 write A keeps B", rd_scale, 16'h5AC3);

    for (int v = 0; v < 7; v++) begin
      wr(VG[v], VS[v]);
      count_to(VG[v], VGAP[v], n);
      chk(n == VEXP[v], "R3 first spacing", n, VEXP[v]);
      chk(sc_level[VG[v]] == 1, "R5 level high at tick", sc_level[VG[v]], 1);
      for (int k = 0; k < VEXP[v]; k++) begin
        pulse(VG[v], VGAP[v], seen);
        if (seen) chk(0, "R4 early tick", k + 1, 2 * VEXP[v]);
      end
      chk(sc_level[VG[v]] == 0, "R5 level low after S", sc_level[VG[v]], 0);
      count_to(VG[v], VGAP[v], n);
      chk(n + VEXP[v] == 2 * VEXP[v], "R4 period", n + VEXP[v], 2 * VEXP[v]);
    end

    // mid-count write of a new value
    wr(0, 4);
    pulse(0, 0, seen); pulse(0, 0, seen);
    wr(0, 6);
    count_to(0, 0, n);
    chk(n == 6, "R6 reload new value", n, 6);

    // rewrite of the same value restarts the count
    wr(0, 3);
    pulse(0, 0, seen); pulse(0, 0, seen);
    wr(0, 3);
    count_to(0, 0, n);
    chk(n == 3, "R6 reload same value", n, 3);

    // write and terminal tick in the same cycle
    wr(0, 2);
    pulse(0, 0, seen);
    wr_en = 1; wr_sel = 0; wr_data = 2; in_tick[0] = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0; in_tick[0] = 0;
    chk(sc_tick[0] == 0 && sc_level[0] == 0, "R6 write wins", {sc_tick[0], sc_level[0]}, 0);
    count_to(0, 0, n);
    chk(n == 2, "R6 tick dropped", n, 2);

    // write clears a high level
    wr(0, 1);
    pulse(0, 0, seen);
    chk(sc_level[0] == 1, "R5 level set", sc_level[0], 1);
    wr(0, 1);
    chk(sc_level[0] == 0, "R5 write clears level", sc_level[0], 0);

    // channel source selection
    ch_sel = 8'b0000_0100;
    in_tick[1] = 1;
    #1;
    chk(ch_tick[3] == 1, "R9 unscaled B", ch_tick[3], 1);
    chk(ch_tick[2] == sc_tick[1], "R9 scaled B", ch_tick[2], sc_tick[1]);
    chk(ch_tick[0] == 0, "R9 group A raw", ch_tick[0], 0);
    in_tick[1] = 0;
    wr(1, 1);
    pulse(1, 0, seen);
    #1;
    chk(ch_tick[2] == 1 && ch_tick[6] == 0, "R9 scaled pass", ch_tick, 8'h04);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule